// File: doc/BRIEF.md
# Two-Tier Vectored IRQ Priority Arbiter

This block picks one winner among 26 pending, already-unmasked IRQ requests and tells the processor where to jump. Requests are grouped into four groups of six plus two stand-alone sources. Inside a group, four sources are ranked by a software-written 2-bit code each, and two more sources always rank below them in a fixed order. Across groups, a second set of 2-bit codes ranks the four groups. The two stand-alone sources rank below every group source.

For the winner the block gives a source number, the fixed address of that source's vector slot, and a ready-made unconditional branch word that jumps from that slot to the source's service routine. Each routine's start address comes in on an input bus. All three results, with a valid flag, are registered once per clock, so a change on the inputs shows up at the outputs one cycle later.

Top module: `vic_prio_arbiter`

## Requirements
- R1: With no request bit set, `hit_o` is 0 on the next cycle and `src_o`, `slot_addr_o` and `jump_word_o` are all zero.
- R2: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge. While reset is held, and for the two cycles it takes the reset to be released inside the block, all outputs are zero.
- R3: Source number n below 24 belongs to group n/6 and position n%6. Positions 0 to 3 are the programmable positions A to D. Group g's 8-bit code field sits in `grp_rank_i[31-8g:24-8g]`. In that field, position A uses bits 7:6, B uses 5:4, C uses 3:2 and D uses 1:0. Among requesting programmable positions of the winning group, the smallest code wins (00 first, 11 last).
- R4: When programmable positions of one group, or groups in the top tier, share a code, the one earlier in the order A, B, C, D wins.
- R5: Positions 4 and 5 of a group win only if no programmable position of that group requests, and position 4 beats position 5.
- R6: Among groups with at least one request, the group with the smallest code in `top_rank_i` wins. Group 0 uses bits 7:6, group 1 uses 5:4, group 2 uses 3:2 and group 3 uses 1:0.
- R7: Source 24 wins only if no source 0 to 23 requests. Source 25 wins only if sources 0 to 24 are all idle.
- R8: The slot address of source n < 24 is 0x20 + 0x20*(n/6) + 4*(n%6). Source 24 has slot address 0xA0 and source 25 has 0xC0.
- R9: The jump word is 0xEA000000 plus the low 24 bits of ((routine − slot − 8) >> 2), computed modulo 2^32. The routine address for source n is `isr_addr_i[32n+31:32n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 26 | Pending and unmasked request per source number |
| grp_rank_i | input | 32 | Four 8-bit in-group code fields, group 0 in the top byte |
| top_rank_i | input | 8 | Group code field for the top tier |
| isr_addr_i | input | 832 | Routine start address per source, 32 bits each, source 0 lowest |
| hit_o | output | 1 | A winner exists |
| src_o | output | 5 | Winning source number |
| slot_addr_o | output | 32 | Vector slot address of the winner |
| jump_word_o | output | 32 | Branch word for the winner's slot |

## Verification
A wrong code comparison or a wrong tie rule shows as a wrong `src_o` in the cycle after the request pattern is applied. A wrong group index corrupts `src_o`, `slot_addr_o` and `jump_word_o` together in that same cycle. No state carries across cycles apart from the output register, so every fault shows one clock after the inputs that trigger it, and it goes away once those inputs go away. Random request patterns run against random code fields, many of them with duplicate codes, so the tie rules and the fixed-tail positions get exercised along with the ordinary ranking.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int GROUPS     = 4;
  localparam int PROG_SLOTS = 4;
  localparam int FIX_SLOTS  = 2;
  localparam int SLOTS      = PROG_SLOTS + FIX_SLOTS;
  localparam int TAILS      = 2;
  localparam int NSRC       = GROUPS * SLOTS + TAILS;
  localparam int ID_W       = $clog2(NSRC);
  localparam int CODE_W     = 2;
  localparam int FIELD_W    = PROG_SLOTS * CODE_W;
  localparam int ADDR_W     = 32;
  localparam int GRP_SEL_W  = $clog2(GROUPS);
  localparam int SLOT_SEL_W = $clog2(SLOTS);

  // Vector slot address of a source number.
  function automatic logic [ADDR_W-1:0] slot_of(input logic [ID_W-1:0] id);
    int n;
    n = int'(id);
    if (n == GROUPS * SLOTS)          return ADDR_W'(32'hA0);
    else if (n == GROUPS * SLOTS + 1) return ADDR_W'(32'hC0);
    else return ADDR_W'(32'h20 + (n / SLOTS) * 32'h20 + (n % SLOTS) * 4);
  endfunction
endpackage

// File: rtl/vic_rank.sv
// Picks the requesting entry with the smallest code; equal codes go to the
// lower index. Entry 0 lives in the top code slot of the field.
module vic_rank #(
  parameter int N = 4,
  parameter int W = 2,
  localparam int SEL_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [N*W-1:0]   codes,
  output logic             any,
  output logic [SEL_W-1:0] sel
);
  logic [W:0] best;

  always_comb begin
    best = {1'b1, {W{1'b0}}};
    sel  = '0;
    any  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && ({1'b0, codes[(N-1-i)*W +: W]} < best)) begin
        best = {1'b0, codes[(N-1-i)*W +: W]};
        sel  = SEL_W'(i);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vic_group_unit.sv
// One group: programmable positions first, then fixed positions in order.
module vic_group_unit
  import vic_pkg::*;
(
  input  logic [SLOTS-1:0]      req,
  input  logic [FIELD_W-1:0]    field,
  output logic                  any,
  output logic [SLOT_SEL_W-1:0] sel
);
  logic                          prog_any;
  logic [$clog2(PROG_SLOTS)-1:0] prog_sel;

  vic_rank #(.N(PROG_SLOTS), .W(CODE_W)) u_rank (
    .req   (req[PROG_SLOTS-1:0]),
    .codes (field),
    .any   (prog_any),
    .sel   (prog_sel)
  );

  always_comb begin
    any = prog_any;
    sel = SLOT_SEL_W'(prog_sel);
    if (!prog_any) begin
      for (int k = FIX_SLOTS - 1; k >= 0; k--) begin
        if (req[PROG_SLOTS + k]) begin
          any = 1'b1;
          sel = SLOT_SEL_W'(PROG_SLOTS + k);
        end
      end
    end
  end
endmodule

// File: rtl/vic_top_unit.sv
// Top tier: groups by programmable code, then the global tail sources.
module vic_top_unit
  import vic_pkg::*;
(
  input  logic [GROUPS-1:0]        grp_any,
  input  logic [FIELD_W-1:0]       field,
  input  logic [TAILS-1:0]         tail_req,
  output logic                     any,
  output logic                     is_tail,
  output logic [GRP_SEL_W-1:0]     grp,
  output logic [$clog2(TAILS)-1:0] tail_sel
);
  logic grp_hit;

  vic_rank #(.N(GROUPS), .W(CODE_W)) u_rank (
    .req   (grp_any),
    .codes (field),
    .any   (grp_hit),
    .sel   (grp)
  );

  always_comb begin
    tail_sel = '0;
    is_tail  = 1'b0;
    for (int k = TAILS - 1; k >= 0; k--) begin
      if (tail_req[k]) begin
        is_tail  = !grp_hit;
        tail_sel = ($clog2(TAILS))'(k);
      end
    end
    any = grp_hit || (|tail_req);
  end
endmodule

// File: rtl/vic_jump_gen.sv
// Branch word from a slot address and a routine address.
module vic_jump_gen #(
  parameter int                AW     = 32,
  parameter int                OFF_W  = 24,
  parameter logic [AW-1:0]     OPCODE = 32'hEA00_0000
) (
  input  logic [AW-1:0] slot,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] word
);
  localparam logic [AW-1:0] OFF_MASK = (AW'(1) << OFF_W) - AW'(1);
  logic [AW-1:0] diff;

  always_comb begin
    diff = target - slot - AW'(8);
    word = OPCODE + ((diff >> 2) & OFF_MASK);
  end
endmodule

// File: rtl/vic_prio_arbiter.sv
module vic_prio_arbiter
  import vic_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          req_i,
  input  logic [GROUPS*FIELD_W-1:0] grp_rank_i,
  input  logic [FIELD_W-1:0]       top_rank_i,
  input  logic [NSRC*ADDR_W-1:0]   isr_addr_i,
  output logic                     hit_o,
  output logic [ID_W-1:0]          src_o,
  output logic [ADDR_W-1:0]        slot_addr_o,
  output logic [ADDR_W-1:0]        jump_word_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Group tier
  logic [GROUPS-1:0]     grp_any;
  logic [SLOT_SEL_W-1:0] grp_sel [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    vic_group_unit u_grp (
      .req   (req_i[g*SLOTS +: SLOTS]),
      .field (grp_rank_i[(GROUPS-1-g)*FIELD_W +: FIELD_W]),
      .any   (grp_any[g]),
      .sel   (grp_sel[g])
    );
  end

  // Top tier
  logic                     top_any;
  logic                     top_is_tail;
  logic [GRP_SEL_W-1:0]     top_grp;
  logic [$clog2(TAILS)-1:0] top_tail;

  vic_top_unit u_top (
    .grp_any  (grp_any),
    .field    (top_rank_i),
    .tail_req (req_i[NSRC-1 -: TAILS]),
    .any      (top_any),
    .is_tail  (top_is_tail),
    .grp      (top_grp),
    .tail_sel (top_tail)
  );

  // Winner, slot and branch word
  logic [ID_W-1:0]   win_d;
  logic [ADDR_W-1:0] slot_d;
  logic [ADDR_W-1:0] isr_d;
  logic [ADDR_W-1:0] word_d;

  always_comb begin
    if (top_is_tail)
      win_d = ID_W'(GROUPS * SLOTS) + ID_W'(top_tail);
    else
      win_d = ID_W'(top_grp) * ID_W'(SLOTS) + ID_W'(grp_sel[top_grp]);
    slot_d = slot_of(win_d);
    isr_d  = isr_addr_i[int'(win_d) * ADDR_W +: ADDR_W];
  end

  vic_jump_gen #(.AW(ADDR_W)) u_jump (
    .slot   (slot_d),
    .target (isr_d),
    .word   (word_d)
  );

  // Output register: next state, then storage
  logic              hit_n;
  logic [ID_W-1:0]   src_n;
  logic [ADDR_W-1:0] slot_n;
  logic [ADDR_W-1:0] word_n;

  always_comb begin
    hit_n  = top_any;
    src_n  = top_any ? win_d  : '0;
    slot_n = top_any ? slot_d : '0;
    word_n = top_any ? word_d : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hit_o       <= 1'b0;
      src_o       <= '0;
      slot_addr_o <= '0;
      jump_word_o <= '0;
    end else begin
      hit_o       <= hit_n;
      src_o       <= src_n;
      slot_addr_o <= slot_n;
      jump_word_o <= word_n;
    end
  end
endmodule

// File: rtl/vic_prio_arbiter_chk.sv
module vic_prio_arbiter_chk
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   req_i,
  input logic              hit_o,
  input logic [ID_W-1:0]   src_o,
  input logic [ADDR_W-1:0] slot_addr_o,
  input logic [ADDR_W-1:0] jump_word_o
);
  logic [NSRC-1:0] req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_i;
  end

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (src_o == '0 && slot_addr_o == '0 && jump_word_o == '0));

  assert_idle_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_i) |=> !hit_o);

  assert_hit_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |=> hit_o);

  assert_winner_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> req_q[src_o]);

  assert_fixed_below_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i[PROG_SLOTS-1:0]) |=> (src_o != ID_W'(PROG_SLOTS) && src_o != ID_W'(PROG_SLOTS + 1)));

  assert_tail_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[GROUPS*SLOTS-1:0] == '0 && req_i[GROUPS*SLOTS]) |=> src_o == ID_W'(GROUPS * SLOTS));

  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (slot_addr_o[1:0] == 2'b00 && slot_addr_o >= 32'h20 && slot_addr_o <= 32'hC0));

  assert_opcode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> jump_word_o[31:24] == 8'hEA);
endmodule

bind vic_prio_arbiter vic_prio_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_i       (req_i),
  .hit_o       (hit_o),
  .src_o       (src_o),
  .slot_addr_o (slot_addr_o),
  .jump_word_o (jump_word_o)
);

// File: tb/sim_vic_prio_arbiter.sv
module sim_vic_prio_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 26;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req;
  logic [31:0]     gr;
  logic [7:0]      tr;
  logic [N*32-1:0] isr;
  logic            hit;
  logic [4:0]      src;
  logic [31:0]     slot;
  logic [31:0]     word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  vic_prio_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .grp_rank_i(gr), .top_rank_i(tr),
    .isr_addr_i(isr), .hit_o(hit), .src_o(src), .slot_addr_o(slot), .jump_word_o(word)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: the smallest global key wins.
  function automatic int ref_win(logic [N-1:0] r, logic [31:0] g, logic [7:0] t);
    int best = -1;
    int bkey = 1 << 30;
    for (int id = 0; id < N; id++) begin
      int key;
      if (!r[id]) continue;
      if (id >= 24) key = 100000 + id;
      else begin
        int grp = id / 6;
        int pos = id % 6;
        int tc  = int'((t >> (6 - 2*grp)) & 8'h3);
        int gc  = int'((g >> (24 - 8*grp + 6 - 2*pos)) & 32'h3);
        key = (tc*4 + grp) * 64 + ((pos < 4) ? (gc*4 + pos) : (16 + pos));
      end
      if (key < bkey) begin bkey = key; best = id; end
    end
    return best;
  endfunction

  function automatic logic [31:0] ref_slot(int id);
    if (id == 24) return 32'hA0;
    if (id == 25) return 32'hC0;
    return 32'(32'h20 + (id / 6) * 32'h20 + (id % 6) * 4);
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] target, logic [31:0] s);
    logic [31:0] d;
    d = target - s - 32'd8;
    return 32'hEA00_0000 + {8'h00, d[25:2]};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int w;
    w = ref_win(req, gr, tr);
    if (w < 0) begin
      cmp({tag, " R1"}, "hit", 32'(hit), 0);
      cmp({tag, " R1"}, "src", 32'(src), 0);
      cmp({tag, " R1"}, "slot", slot, 0);
      cmp({tag, " R1"}, "word", word, 0);
    end else begin
      cmp(tag, "hit", 32'(hit), 1);
      cmp(tag, "src", 32'(src), 32'(w));
      cmp({tag, " R8"}, "slot", slot, ref_slot(w));
      cmp({tag, " R9"}, "word", word, ref_word(isr[w*32 +: 32], ref_slot(w)));
    end
  endtask

  // Drive on a falling edge, sample on the next falling edge (one register).
  task automatic apply(logic [N-1:0] r, logic [31:0] g, logic [7:0] t, string tag);
    @(negedge clk);
    req = r; gr = g; tr = t;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0;
    req = '1; gr = 32'h1b1b1b1b; tr = 8'h1b;
    for (int i = 0; i < N; i++) isr[i*32 +: 32] = 32'h0C00_0000 + $urandom % 32'h0010_0000 * 4;
    repeat (3) @(negedge clk);
    // R2: outputs held at zero under reset even with all requests
    cmp("R2 in reset", "hit", 32'(hit), 0);
    cmp("R2 in reset", "word", word, 0);
    rst_n = 1;
    @(negedge clk);
    cmp("R2 release sync", "hit", 32'(hit), 0);
    req = '0;
    repeat (3) @(negedge clk);

    apply('0, 32'h1b1b1b1b, 8'h1b, "R1 idle");
    apply('1, 32'h1b1b1b1b, 8'h1b, "R6 default all");
    // R3: group 0 codes A=11 B=10 C=00 D=01 -> C wins
    apply(26'h0F, {8'b11_10_00_01, 24'h1b1b1b}, 8'h1b, "R3 group0 order");
    apply(26'h0B, {8'b11_10_00_01, 24'h1b1b1b}, 8'h1b, "R3 group0 D");
    // R4: all-equal codes, B and D request -> B
    apply(26'h0A, 32'h00000000, 8'h1b, "R4 tie");
    apply(26'h3 << 12, 32'h1b1b1b1b, 8'h00, "R4 tie top");
    // R5: fixed positions of group 2
    apply(26'h3 << 16, 32'h1b1b1b1b, 8'h1b, "R5 fixed A");
    apply(26'h1 << 17, 32'h1b1b1b1b, 8'h1b, "R5 fixed B");
    apply((26'h1 << 17) | (26'h1 << 15), 32'h1b1b1b1b, 8'h1b, "R5 prog over fixed");
    // R6: group 3 code 00, group 1 code 01
    apply((26'h1 << 6) | (26'h1 << 18), 32'h1b1b1b1b, 8'b11_01_10_00, "R6 top order");
    apply((26'h1 << 11) | (26'h1 << 18), 32'h1b1b1b1b, 8'b11_01_10_00, "R6 fixed in higher group");
    // R7: global tails
    apply(26'h3 << 24, 32'h1b1b1b1b, 8'h1b, "R7 tails both");
    apply(26'h1 << 25, 32'h1b1b1b1b, 8'h1b, "R7 tail last");
    apply((26'h1 << 25) | 26'h20, 32'h1b1b1b1b, 8'h1b, "R7 group over tail");
    // R9: wrap-around target below slot
    isr[5*32 +: 32] = 32'h0000_0010;
    apply(26'h20, 32'h1b1b1b1b, 8'h1b, "R9 backward jump");

    for (int it = 0; it < 4000; it++) begin
      logic [N-1:0] r;
      r = N'($urandom & $urandom & $urandom);
      if (it % 7 == 0) r = N'($urandom) & (26'h3 << 24);
      if (it % 11 == 0) r = '0;
      if (it % 50 == 0) for (int i = 0; i < N; i++) isr[i*32 +: 32] = $urandom;
      apply(r, $urandom, 8'($urandom), "R3 R6 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule